// File: doc/BRIEF.md
# Redundant Unique-ID Copy Checker

This block sits on the host side of a flash interface. It watches the byte stream that comes back after a unique-identifier read and picks out the first stored copy of the identifier that proves intact. The identifier is held as a run of redundant copies placed one after another. Each copy has a data half followed by a complement half, and byte k of the complement half must be the bitwise inverse of byte k of the data half.

A pulse on `start` arms the checker and clears all of its state. The stream then arrives one byte per cycle where `in_valid` is high. The checker keeps the data half of the current copy. As each complement byte arrives, it tests that byte against its partner. If a copy passes, `done` goes high and `id_out` and `copy_idx` give the result. If a copy fails, the checker moves on to the next copy. If every copy fails, `fail` is raised.

Top module: `uid_copy_checker`

## Requirements
- R1: After reset, `done` and `fail` are 0, `id_out` is all zeros and `copy_idx` is 0.
- R2: A copy is 32 bytes. Bytes 0..15 are data and bytes 16..31 are their complements. Byte 16+k pairs with byte k, and the copy is valid only when every pair XORs to FFh.
- R3: On the first valid copy, `done` is 1 on the cycle after the copy's last byte is accepted. At that point `id_out` holds the copy's data bytes, with byte 0 in bits 7:0 and byte k in bits 8k+7:8k, and `copy_idx` holds the copy's position counted from 0.
- R4: When a copy fails, `done` stays 0 and checking restarts at byte 0 of the next copy.
- R5: When all 16 copies fail, `fail` is 1 on the cycle after the 512th accepted byte, and not before it.
- R6: Once `done` or `fail` is 1, further valid bytes change none of the outputs until the next `start`.
- R7: `start` clears the stored bytes, the copy counter and both flags. A byte presented in the same cycle as `start` is discarded.
- R8: Cycles with `in_valid` low do not advance the byte position.
- R9: Before the first `start` after reset, valid bytes are ignored.
- R10: `done` and `fail` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that clears the state and arms the checker |
| in_valid | input | 1 | `in_byte` carries a stream byte this cycle |
| in_byte | input | 8 | Stream byte |
| done | output | 1 | A valid copy was found |
| fail | output | 1 | Every copy failed |
| copy_idx | output | 4 | Index of the accepted copy |
| id_out | output | 128 | Data half of the accepted copy |

## Verification
The assertions take for granted that `start` comes as a single-cycle pulse. They also assume that the stream is aligned to copy boundaries from the first byte after `start`, so that byte position alone decides whether a byte is data or complement. The stimulus always releases `start` before it sends the first byte. The one exception is the discard case, where a byte is deliberately presented during `start`. Stream gaps are made only by lowering `in_valid` and never by any other signal.

// File: rtl/uidv_pkg.sv
package uidv_pkg;
   typedef enum logic [1:0] {
      UV_IDLE    = 2'd0,
      UV_RUN     = 2'd1,
      UV_FOUND   = 2'd2,
      UV_EXHAUST = 2'd3
   } uv_state_t;
endpackage

// File: rtl/uidv_pair_check.sv
module uidv_pair_check #(
   parameter int  DW      = 8,
   parameter bit  USE_XOR = 1'b1
) (
   input  logic [DW-1:0] data_b,
   input  logic [DW-1:0] comp_b,
   output logic          match
);
   generate
      if (DW < 1) begin : g_bad_width
         $error("uidv_pair_check: DW must be at least 1");
      end
      if (USE_XOR) begin : g_xor
         // XOR of a byte with its inverse is all ones
         assign match = &(data_b ^ comp_b);
      end else begin : g_inv
         // Equivalent direct comparison against the inverted byte
         assign match = (comp_b == ~data_b);
      end
   endgenerate
endmodule

// File: rtl/uidv_half_store.sv
module uidv_half_store #(
   parameter int DW   = 8,
   parameter int HALF = 16,
   localparam int IDX_W = $clog2(HALF)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [DW-1:0]      wr_data,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [DW-1:0]      rd_data,
   output logic [HALF*DW-1:0] flat
);
   logic [DW-1:0] mem [HALF];

   generate
      if (HALF < 2) begin : g_bad_half
         $error("uidv_half_store: HALF must be at least 2");
      end
      for (genvar g = 0; g < HALF; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mem[g] <= '0;
            end else if (clr) begin
               mem[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
               mem[g] <= wr_data;
            end
         end
         assign flat[g*DW +: DW] = mem[g];
      end
   endgenerate

   assign rd_data = mem[rd_idx];

   // R6: with no write and no clear the stored half does not move
   p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !clr) |=> $stable(flat));

   // R7: a clear empties the store
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (flat == '0));
endmodule

// File: rtl/uidv_walker.sv
module uidv_walker
   import uidv_pkg::*;
#(
   parameter int HALF   = 16,
   parameter int COPIES = 16,
   localparam int POS_W = $clog2(2*HALF),
   localparam int IDX_W = $clog2(HALF),
   localparam int CPY_W = (COPIES > 1) ? $clog2(COPIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             in_valid,
   input  logic             pair_ok,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic [IDX_W-1:0] rd_idx,
   output logic [CPY_W-1:0] copy,
   output logic             found,
   output logic             exhausted
);
   localparam logic [POS_W-1:0] HALF_P = POS_W'(HALF);
   localparam logic [POS_W-1:0] LAST_P = POS_W'(2*HALF-1);
   localparam logic [CPY_W-1:0] LAST_C = CPY_W'(COPIES-1);

   uv_state_t        state;
   logic [POS_W-1:0] pos;
   logic             ok;
   logic             take, first_half, ok_next;
   logic [POS_W-1:0] rd_off;

   generate
      if (COPIES < 1) begin : g_bad_copies
         $error("uidv_walker: COPIES must be at least 1");
      end
   endgenerate

   assign take       = in_valid && !start && (state == UV_RUN);
   assign first_half = (pos < HALF_P);
   assign ok_next    = ok && pair_ok;
   assign rd_off     = pos - HALF_P;
   assign rd_idx     = rd_off[IDX_W-1:0];
   assign wr_idx     = pos[IDX_W-1:0];
   assign wr_en      = take && first_half;
   assign found      = (state == UV_FOUND);
   assign exhausted  = (state == UV_EXHAUST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= UV_IDLE;
         pos   <= '0;
         copy  <= '0;
         ok    <= 1'b1;
      end else if (start) begin
         state <= UV_RUN;
         pos   <= '0;
         copy  <= '0;
         ok    <= 1'b1;
      end else if (take) begin
         if (first_half) begin
            pos <= pos + 1'b1;
         end else if (pos == LAST_P) begin
            if (ok_next) begin
               state <= UV_FOUND;
            end else if (copy == LAST_C) begin
               state <= UV_EXHAUST;
            end else begin
               copy <= copy + 1'b1;
               pos  <= '0;
               ok   <= 1'b1;
            end
         end else begin
            pos <= pos + 1'b1;
            ok  <= ok_next;
         end
      end
   end

   // R10: the two end flags exclude each other
   p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(found && exhausted));

   // R6: a found result holds until the next start
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (found && !start) |=> (found && $stable(copy)));

   // R5: exhaustion only ever happens on the final copy
   p_fail_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(exhausted) |-> (copy == LAST_C));

   // R8: without a valid byte the position does not move
   p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !start) |=> ($stable(pos) && $stable(copy)));

   // R9: an unarmed checker stays unarmed without start
   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == UV_IDLE && !start) |=> (state == UV_IDLE));
endmodule

// File: rtl/uid_copy_checker.sv
module uid_copy_checker #(
   parameter int BYTE_W  = 8,
   parameter int HALF    = 16,
   parameter int COPIES  = 16,
   parameter bit USE_XOR = 1'b1,
   localparam int IDX_W  = $clog2(HALF),
   localparam int CPY_W  = (COPIES > 1) ? $clog2(COPIES) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic                   in_valid,
   input  logic [BYTE_W-1:0]      in_byte,
   output logic                   done,
   output logic                   fail,
   output logic [CPY_W-1:0]       copy_idx,
   output logic [HALF*BYTE_W-1:0] id_out
);
   logic             wr_en, pair_ok;
   logic [IDX_W-1:0] wr_idx, rd_idx;
   logic [BYTE_W-1:0] partner;

   uidv_walker #(.HALF(HALF), .COPIES(COPIES)) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .in_valid  (in_valid),
      .pair_ok   (pair_ok),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .rd_idx    (rd_idx),
      .copy      (copy_idx),
      .found     (done),
      .exhausted (fail)
   );

   uidv_half_store #(.DW(BYTE_W), .HALF(HALF)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (in_byte),
      .rd_idx  (rd_idx),
      .rd_data (partner),
      .flat    (id_out)
   );

   uidv_pair_check #(.DW(BYTE_W), .USE_XOR(USE_XOR)) u_pair (
      .data_b (partner),
      .comp_b (in_byte),
      .match  (pair_ok)
   );

   // R7: start drops both flags on the following cycle
   p_start_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!done && !fail && copy_idx == '0));
endmodule

// File: tb/test_uid_copy_checker.sv
module test_uid_copy_checker;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         in_valid = 1'b0;
   logic [7:0]   in_byte = '0;
   logic         done, fail;
   logic [3:0]   copy_idx;
   logic [127:0] id_out;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   uid_copy_checker i_uid_copy_checker (
      .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
      .in_byte(in_byte), .done(done), .fail(fail),
      .copy_idx(copy_idx), .id_out(id_out)
   );

   task automatic chk(input bit cond, input string tag,
                      input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!cond) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] dbyte(input int seed, input int k);
      return 8'((seed * 37) + (k * 13) + 5);
   endfunction

   function automatic logic [127:0] idvec(input int seed);
      logic [127:0] v;
      for (int k = 0; k < 16; k++) v[k*8 +: 8] = dbyte(seed, k);
      return v;
   endfunction

   // all tasks begin and end at a falling edge
   task automatic put(input logic [7:0] b);
      in_valid = 1'b1;
      in_byte  = b;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic pulse_start(input bit with_byte);
      start    = 1'b1;
      in_valid = with_byte;
      in_byte  = 8'hA5;
      @(negedge clk);
      start    = 1'b0;
      in_valid = 1'b0;
   endtask

   // bad_pos < 0: intact copy; else the pair at bad_pos (0..15) is broken
   task automatic send_copy(input int seed, input int bad_pos, input bit gaps);
      for (int k = 0; k < 32; k++) begin
         logic [7:0] b;
         if (k < 16) b = dbyte(seed, k);
         else begin
            b = ~dbyte(seed, k - 16);
            if (k - 16 == bad_pos) b = b ^ 8'h10;
         end
         put(b);
         if (gaps && (k % 3 == 0)) repeat (2) @(negedge clk);
      end
   endtask

   task automatic t_reset();
      chk(!done && !fail, "R1 flags", {done, fail}, 0);
      chk(id_out == '0, "R1 id", id_out, 0);
      chk(copy_idx == 0, "R1 idx", copy_idx, 0);
   endtask

   task automatic t_before_start();
      send_copy(1, -1, 1'b0);
      chk(!done && id_out == '0, "R9 ignored before start", id_out, 0);
   endtask

   task automatic t_first_good();
      pulse_start(1'b0);
      send_copy(2, -1, 1'b0);
      chk(done && !fail, "R3 done", {done, fail}, 2'b10);
      chk(id_out == idvec(2), "R2 R3 id", id_out, idvec(2));
      chk(copy_idx == 0, "R3 idx", copy_idx, 0);
   endtask

   task automatic t_fallback();
      pulse_start(1'b0);
      send_copy(3, 15, 1'b0);
      chk(!done && !fail, "R4 no done after bad copy", {done, fail}, 0);
      send_copy(4, 0, 1'b0);
      chk(!done, "R4 still searching", done, 0);
      send_copy(5, -1, 1'b0);
      chk(done && copy_idx == 2, "R4 fallback idx", copy_idx, 2);
      chk(id_out == idvec(5), "R4 fallback id", id_out, idvec(5));
   endtask

   task automatic t_ignore_after();
      send_copy(9, -1, 1'b0);
      send_copy(10, 3, 1'b0);
      chk(done && !fail && copy_idx == 2, "R6 idx held", copy_idx, 2);
      chk(id_out == idvec(5), "R6 id held", id_out, idvec(5));
   endtask

   task automatic t_gaps();
      pulse_start(1'b0);
      send_copy(6, -1, 1'b1);
      chk(done && copy_idx == 0, "R8 gaps done", {done, copy_idx}, 5'h10);
      chk(id_out == idvec(6), "R8 gaps id", id_out, idvec(6));
   endtask

   task automatic t_all_fail();
      pulse_start(1'b0);
      chk(!done && !fail && id_out == '0, "R7 cleared", id_out, 0);
      for (int c = 0; c < 15; c++) send_copy(20 + c, c, 1'b0);
      // last copy: all but the final byte
      for (int k = 0; k < 31; k++)
         put(k < 16 ? dbyte(40, k) : ~dbyte(40, k - 16));
      chk(!fail, "R5 not before 512th", fail, 0);
      put(dbyte(40, 15));
      chk(fail && !done, "R5 R10 fail", {done, fail}, 2'b01);
      send_copy(41, -1, 1'b0);
      chk(fail && !done, "R6 fail held", {done, fail}, 2'b01);
   endtask

   task automatic t_restart_discard();
      pulse_start(1'b1);
      chk(!done && !fail && copy_idx == 0, "R7 flags cleared", {done, fail, copy_idx}, 0);
      send_copy(50, -1, 1'b0);
      chk(done && copy_idx == 0, "R7 start byte discarded", copy_idx, 0);
      chk(id_out == idvec(50), "R7 id after restart", id_out, idvec(50));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_before_start();
      t_first_good();
      t_fallback();
      t_ignore_after();
      t_gaps();
      t_all_fail();
      t_restart_discard();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end
endmodule